// File: doc/BRIEF.md
# Three-Lane Grey-Level PWM Driver

This block turns a 5-bit brightness code for each of three colour lanes into a pulse-width-modulated output. A grey-clock enable paces the pulses. All lanes share one free-running period counter that is 256 enable ticks long. Each lane's output is high from the start of the period until that lane's on-width has elapsed.

A mode input selects how a code becomes an on-width. In linear mode the on-width is a fixed multiple of the code plus one. In expansion mode a fixed curve spreads the 32 codes across the full 256-grade range, which gives fine steps at the dark end.

Codes are written into a shadow register by a load strobe. They move into the active register only at the end of a period, and the mode input is sampled at the same point. Between updates the block repeats the same duty cycle indefinitely without further input.

Top module: `lumen_pwm`

## Requirements
- R1: After reset the count is 0, all shadow and active codes are 0, and the active mode is expansion. Every output is therefore high at count 0 of the first period and low for the rest of it.
- R2: In expansion mode (active mode 0) a code c gives an on-width of 1 + c + floor(224·c²/961) ticks. Code 0 gives 1 tick and code 31 gives 256 ticks, which is high for the whole period.
- R3: In linear mode (active mode 1) a code c gives an on-width of 4·(c+1) ticks, from 4 up to 128. The output is never high at a count of 128 or above.
- R4: The period counter advances by one on every clock with `gclk_en` high and wraps from 255 to 0. An output is high exactly while count < on-width, so every output is high at count 0.
- R5: Lane i takes `level_in[5i+4:5i]` into its shadow on any clock with `load` high. The active codes change only on a clock where `gclk_en` is high and the count is 255, and they take the shadow value held before that clock. A load in that same clock therefore takes effect one period later.
- R6: `mode_lin` is sampled only on the wrap clock defined in R5. A change at any other time leaves the current period unchanged.
- R7: With no load, the output waveform repeats period after period. While `gclk_en` is low, the count and all outputs hold still.
- R8: All lanes share one count, so a rising edge on any output happens only at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gclk_en | input | 1 | Grey-clock tick enable; one tick per high cycle |
| mode_lin | input | 1 | 1 selects linear mode, 0 selects expansion mode; applied at the next wrap |
| load | input | 1 | Write strobe for the shadow codes |
| level_in | input | 15 | Packed codes; lane i uses bits [5i+4:5i] |
| pwm_out | output | 3 | Per-lane PWM outputs; bit i belongs to lane i |

## Verification
The bench builds the block with its default parameters: three lanes, 5-bit codes, a 256-tick period and a linear step of 4. This configuration is small enough to sweep every code in both modes over complete periods and compare all three outputs on every cycle. It also reaches the timing corners: a load and a mode change in the middle of a period, a load on the exact wrap clock, and irregular or paused grey-clock enables. Pulse widths at the extreme codes are also counted directly and compared with the arithmetic formulas.

// File: rtl/lumen_pwm_pkg.sv
package lumen_pwm_pkg;

  // On-width of the expansion curve: linear part plus a quadratic term
  // scaled so the top code fills the whole period.
  function automatic int unsigned nl_width(int unsigned code,
                                           int unsigned code_max,
                                           int unsigned period);
    return 1 + code + ((period - 1 - code_max) * code * code) / (code_max * code_max);
  endfunction

  function automatic int unsigned lin_width(int unsigned code, int unsigned step);
    return (code + 1) * step;
  endfunction

endpackage

// File: rtl/lumen_rst_sync.sv
module lumen_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/lumen_pwm_timebase.sv
module lumen_pwm_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == {CNT_W{1'b1}});

endmodule

// File: rtl/lumen_pwm_map.sv
module lumen_pwm_map
  import lumen_pwm_pkg::*;
#(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_STEP = 4
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              lin_i,
  output logic [CNT_W:0]    width_o
);

  localparam int unsigned NCODE    = 2 ** CODE_W;
  localparam int unsigned CODE_MAX = NCODE - 1;
  localparam int unsigned PERIOD   = 2 ** CNT_W;
  localparam int unsigned WID_W    = CNT_W + 1;

  logic [WID_W-1:0] nl_tbl  [NCODE];
  logic [WID_W-1:0] lin_tbl [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tbl
    localparam int unsigned NL_W  = nl_width(g, CODE_MAX, PERIOD);
    localparam int unsigned LIN_W = lin_width(g, LIN_STEP);
    assign nl_tbl[g]  = WID_W'(NL_W);
    assign lin_tbl[g] = WID_W'(LIN_W);
  end

  assign width_o = lin_i ? lin_tbl[code_i] : nl_tbl[code_i];

endmodule

// File: rtl/lumen_pwm_lane.sv
module lumen_pwm_lane #(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              wrap_i,
  input  logic              lin_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] act_code_o,
  output logic              pwm_o
);

  logic [CODE_W-1:0] shadow_q, shadow_d;
  logic [CODE_W-1:0] act_q, act_d;
  logic [CNT_W:0]    width;

  always_comb begin
    shadow_d = shadow_q;
    act_d    = act_q;
    if (load_i) begin
      shadow_d = code_i;
    end
    if (wrap_i) begin
      act_d = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
    end
  end

  lumen_pwm_map #(
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .LIN_STEP(LIN_STEP)
  ) u_map (
    .code_i (act_q),
    .lin_i  (lin_i),
    .width_o(width)
  );

  assign pwm_o      = ({1'b0, cnt_i} < width);
  assign act_code_o = act_q;

endmodule

// File: rtl/lumen_pwm.sv
module lumen_pwm #(
  parameter int unsigned LANES    = 3,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_STEP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gclk_en,
  input  logic                     mode_lin,
  input  logic                     load,
  input  logic [LANES*CODE_W-1:0]  level_in,
  output logic [LANES-1:0]         pwm_out
);

  localparam int unsigned CODES_W = LANES * CODE_W;

  logic               srst_n;
  logic [CNT_W-1:0]   tick_cnt;
  logic               wrap;
  logic               mode_act_q, mode_act_d;
  logic [CODES_W-1:0] act_codes;

  lumen_rst_sync u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  lumen_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk   (clk),
    .rst_n (srst_n),
    .tick_i(gclk_en),
    .cnt_o (tick_cnt),
    .wrap_o(wrap)
  );

  always_comb begin
    mode_act_d = mode_act_q;
    if (wrap) begin
      mode_act_d = mode_lin;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_act_q <= 1'b0;
    end else begin
      mode_act_q <= mode_act_d;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lumen_pwm_lane #(
      .CODE_W  (CODE_W),
      .CNT_W   (CNT_W),
      .LIN_STEP(LIN_STEP)
    ) u_lane (
      .clk       (clk),
      .rst_n     (srst_n),
      .load_i    (load),
      .code_i    (level_in[i*CODE_W +: CODE_W]),
      .wrap_i    (wrap),
      .lin_i     (mode_act_q),
      .cnt_i     (tick_cnt),
      .act_code_o(act_codes[i*CODE_W +: CODE_W]),
      .pwm_o     (pwm_out[i])
    );
  end

endmodule

// File: rtl/lumen_pwm_chk.sv
module lumen_pwm_chk #(
  parameter int unsigned LANES    = 3,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_STEP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    gclk_en,
  input logic [CNT_W-1:0]        cnt,
  input logic                    mode_act,
  input logic [LANES*CODE_W-1:0] act_codes,
  input logic [LANES-1:0]        pwm_out
);

  localparam int unsigned LIN_TOP = LIN_STEP * (2 ** CODE_W);

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gclk_en && cnt == {CNT_W{1'b1}}) |=> (cnt == '0));

  // R4
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (&pwm_out));

  // R3
  lin_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act && ({1'b0, cnt} >= (CNT_W + 1)'(LIN_TOP))) |-> (pwm_out == '0));

  // R5
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gclk_en && cnt == {CNT_W{1'b1}}) |=> $stable(act_codes));

  // R6
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gclk_en && cnt == {CNT_W{1'b1}}) |=> $stable(mode_act));

  // R7
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gclk_en |=> ($stable(cnt) && $stable(pwm_out)));

  // R8
  aligned_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out & ~$past(pwm_out)) != '0) |-> (cnt == '0));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    // R2
    nl_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_act && act_codes[i*CODE_W +: CODE_W] == '0 && cnt != '0) |-> !pwm_out[i]);
    // R2
    nl_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_act && act_codes[i*CODE_W +: CODE_W] == {CODE_W{1'b1}}) |-> pwm_out[i]);
  end

endmodule

bind lumen_pwm lumen_pwm_chk #(
  .LANES   (LANES),
  .CODE_W  (CODE_W),
  .CNT_W   (CNT_W),
  .LIN_STEP(LIN_STEP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gclk_en  (gclk_en),
  .cnt      (tick_cnt),
  .mode_act (mode_act_q),
  .act_codes(act_codes),
  .pwm_out  (pwm_out)
);

// File: tb/test_lumen_pwm.sv
`timescale 1ns/1ps
module test_lumen_pwm;

  logic        clk;
  logic        rst_n;
  logic        gclk_en;
  logic        mode_lin;
  logic        load;
  logic [14:0] level_in;
  logic [2:0]  pwm_out;

  int checks;
  int failures;
  bit chk_on;
  string tag;

  // Requirement-level model state
  int          m_cnt;
  logic [14:0] m_sh;
  logic [14:0] m_act;
  bit          m_mode;

  lumen_pwm i_lumen_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .gclk_en (gclk_en),
    .mode_lin(mode_lin),
    .load    (load),
    .level_in(level_in),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_width(int c, bit lin);
    if (lin) return 4 * (c + 1);
    return 1 + c + (224 * c * c) / 961;
  endfunction

  function automatic logic [2:0] exp_pwm();
    logic [2:0] v;
    for (int i = 0; i < 3; i++) begin
      v[i] = (m_cnt < exp_width(int'(m_act[i*5 +: 5]), m_mode));
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= 0;
      m_sh   <= '0;
      m_act  <= '0;
      m_mode <= 1'b0;
    end else begin
      if (gclk_en) m_cnt <= (m_cnt + 1) % 256;
      if (load) m_sh <= level_in;
      if (gclk_en && m_cnt == 255) begin
        m_act  <= m_sh;
        m_mode <= mode_lin;
      end
    end
  end

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pwm_out=%b expected=%b (count %0d)", req, act, exp, m_cnt);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) check(tag, pwm_out, exp_pwm());
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_vals(int a, int b, int c);
    @(negedge clk);
    level_in = {5'(c), 5'(b), 5'(a)};
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic to_start();
    while (m_cnt != 0) @(negedge clk);
  endtask

  // Measures lane-0 high ticks over one full period starting at count 0
  task automatic measure(string req, int want);
    int hi;
    hi = 0;
    to_start();
    for (int k = 0; k < 256; k++) begin
      if (pwm_out[0]) hi++;
      @(negedge clk);
    end
    checks++;
    if (hi != want) begin
      failures++;
      $display("FAIL %s: lane0 width=%0d expected=%0d", req, hi, want);
    end
  endtask

  initial begin
    int fin;
    fin = 0;
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    checks = 0; failures = 0; chk_on = 0; tag = "R1";
    rst_n = 1'b0; gclk_en = 1'b0; mode_lin = 1'b0; load = 1'b0; level_in = '0;
    run(3);
    rst_n = 1'b1;
    run(4);
    // R1: reset state at count 0, then one tick later
    check("R1", pwm_out, 3'b111);
    gclk_en = 1'b1;
    run(1);
    check("R1", pwm_out, 3'b000);
    chk_on = 1;
    run(300);

    // R2 sweep, expansion mode
    tag = "R2"; mode_lin = 1'b0;
    for (int c = 0; c < 32; c++) begin
      load_vals(c, 31 - c, (c * 7) % 32);
      to_start(); run(1); to_start(); run(1);
    end
    load_vals(0, 3, 9);  measure("R2", 1);
    load_vals(31, 3, 9); to_start(); run(1); measure("R2", 256);

    // R3 sweep, linear mode
    tag = "R3"; mode_lin = 1'b1;
    for (int c = 0; c < 32; c++) begin
      load_vals((c * 11) % 32, c, 31 - c);
      to_start(); run(1); to_start(); run(1);
    end
    load_vals(0, 1, 2);  to_start(); run(1); measure("R3", 4);
    load_vals(31, 1, 2); to_start(); run(1); measure("R3", 128);

    // R5: load mid-period and on the exact wrap clock
    tag = "R5";
    load_vals(5, 5, 5); to_start(); run(100);
    load_vals(31, 0, 17); run(300);
    while (m_cnt != 254) @(negedge clk);
    @(negedge clk);
    level_in = {5'd2, 5'd20, 5'd9}; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    run(520);

    // R6: mode change mid-period
    tag = "R6";
    load_vals(12, 24, 7); to_start(); run(60);
    mode_lin = 1'b0; run(100); mode_lin = 1'b1; run(400);
    mode_lin = 1'b0; run(600);

    // R7: free-run repeat, paused and irregular enables
    tag = "R7";
    load_vals(9, 18, 27); run(800);
    gclk_en = 1'b0; run(40); gclk_en = 1'b1; run(50);
    lfsr = 8'h5a;
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      gclk_en = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    gclk_en = 1'b1;

    // R8 and R4: shared count, mixed codes
    tag = "R8";
    load_vals(0, 15, 31); run(600);
    tag = "R4";
    mode_lin = 1'b1; load_vals(7, 30, 1); run(600);

    chk_on = 0;
    run(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule